// File: doc/BRIEF.md
# Comparator output digital filter

This block takes the asynchronous one-bit decision of an analog comparator into the digital clock domain and conditions it. The bit is synchronized through a flop chain. It may be inverted. While the comparator enable is low it is forced to zero. The result is exported as the unfiltered value.

A run-length glitch filter follows. It changes its output only after a programmed number of consecutive samples that disagree with the current output. The run length is a power of two chosen by a 3-bit code, and code zero bypasses the filter. A sample prescaler takes one sample every 1, 2 or 4 clocks, which stretches the longest run to 128 or 256 clocks.

Both the unfiltered and the filtered value are exported for edge detection and status readback. An output-select bit picks which of the two drives the external pin. Any change of the filter code or of the prescaler code restarts the filter from a clean state.

Top module: `cmp_glitch_filter`

## Requirements
- R1: `raw_o` shows `cmp_raw_i` (XOR `inv_i`) two clock edges after `cmp_raw_i` changes. After one edge it still holds the old value.
- R2: While `en_i` is 0, `raw_o`, `flt_o` and `pin_o` are 0 in that same cycle. After re-enable, `flt_o` starts from 0 when the filter is active.
- R3: With `flt_cnt_i` = 3'b000 the filter is bypassed: `flt_o` equals `raw_o` in the same cycle.
- R4: With `flt_cnt_i` = c, where c is 1 to 7, `flt_o` takes a new value only after 2^(c-1) consecutive samples that differ from it. Any sample equal to `flt_o` restarts the count from zero.
- R5: `flt_div_i` sets the sample rate: 2'b00 samples every clock, 2'b01 every 2nd clock and 2'b10 every 4th clock. 2'b11 samples every clock.
- R6: With `flt_cnt_i` = 3'b111, a divider of 2'b01 gives an effective window of 128 clocks and 2'b10 gives 256 clocks.
- R7: `pin_o` carries `raw_o` when `out_sel_i` is 0 and `flt_o` when it is 1.
- R8: A change of `flt_cnt_i` or `flt_div_i` clears the run count, the prescaler and the filtered value at the next edge. The clear takes precedence over a filter flip due in that same edge.
- R9: `inv_i` = 1 inverts the synchronized comparator value before the filter and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Comparator enable; outputs are 0 while low |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| inv_i | input | 1 | Invert the comparator value |
| flt_cnt_i | input | CNT_W | Filter run-length code, 0 = bypass |
| flt_div_i | input | 2 | Sample prescaler code |
| out_sel_i | input | 1 | Pin source: 0 unfiltered, 1 filtered |
| raw_o | output | 1 | Synchronized, gated, optionally inverted value |
| flt_o | output | 1 | Filtered value |
| pin_o | output | 1 | Selected value for the external pin |

## Verification
The interesting collision is a configuration change that falls in the same cycle as the filter's last sample, the one that would flip the output. The bench drives a long enough run to within one sample of its threshold. On the negedge before the flipping edge, it rewrites the divider code from 2'b00 to the equivalent 2'b11. The filtered value must then stay 0 across that edge and flip only after a full fresh run of the same length. A design that let the flip win, or that ignored a change with no effect on the sample rate, is caught at the exact edge.

// File: rtl/cmp_flt_pkg.sv
package cmp_flt_pkg;
  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_2   = 2'b01,
    DIV_4   = 2'b10,
    DIV_RSV = 2'b11
  } div_code_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cmp_prescale.sv
module cmp_prescale
  import cmp_flt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  div_code_e div_i,
  output logic      tick_o
);
  logic [1:0] cnt_q;
  logic [1:0] last;

  always_comb begin
    unique case (div_i)
      DIV_2:   last = 2'd1;
      DIV_4:   last = 2'd3;
      default: last = 2'd0;  // reserved code runs at full rate
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == last)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 2'd1;
  end

  assign tick_o = !clr_i && (cnt_q == last);
endmodule

// File: rtl/cmp_run_filter.sv
module cmp_run_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] code_i,
  input  logic             smp_i,
  output logic             flt_o
);
  localparam int RUN_W = (1 << CNT_W) - 1;

  logic [RUN_W-1:0] run_q, run_inc, need;
  logic             flt_q;
  logic             bypass;

  assign bypass  = (code_i == '0);
  assign need    = bypass ? '0 : (RUN_W'(1) << (code_i - CNT_W'(1)));
  assign run_inc = run_q + RUN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      flt_q <= 1'b0;
    end else if (clr_i || bypass) begin
      run_q <= '0;
      flt_q <= 1'b0;
    end else if (tick_i) begin
      if (smp_i == flt_q) begin
        run_q <= '0;
      end else if (run_inc == need) begin
        run_q <= '0;
        flt_q <= smp_i;
      end else begin
        run_q <= run_inc;
      end
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter
  import cmp_flt_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmp_raw_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] flt_cnt_i,
  input  logic [1:0]       flt_div_i,
  input  logic             out_sel_i,
  output logic             raw_o,
  output logic             flt_o,
  output logic             pin_o
);
  localparam int CFG_W = CNT_W + 2;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             clr, sync_q, tick, flt_q, raw;

  assign cfg_now = {flt_cnt_i, flt_div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_now;
  end

  // restart on disable or any filter reconfiguration
  assign clr = !en_i || (cfg_now != cfg_q);

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_raw_i),
    .q_o    (sync_q)
  );

  assign raw = en_i & (sync_q ^ inv_i);

  cmp_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .div_i  (div_code_e'(flt_div_i)),
    .tick_o (tick)
  );

  cmp_run_filter #(.CNT_W(CNT_W)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .code_i (flt_cnt_i),
    .smp_i  (raw),
    .flt_o  (flt_q)
  );

  assign raw_o = raw;
  assign flt_o = en_i & ((flt_cnt_i == '0) ? raw : flt_q);
  assign pin_o = out_sel_i ? flt_o : raw_o;
endmodule

// File: rtl/cmp_glitch_filter_chk.sv
module cmp_glitch_filter_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] flt_cnt_i,
  input logic [1:0]       flt_div_i,
  input logic             out_sel_i,
  input logic             raw_o,
  input logic             flt_o,
  input logic             pin_o
);
  logic [CNT_W+1:0] cfg_d;
  logic             vld_q, steady_d, raw_d, flt_d, en_d, steady;

  assign steady = vld_q && en_i && ({flt_cnt_i, flt_div_i} == cfg_d) && (flt_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      cfg_d    <= '0;
      steady_d <= 1'b0;
      raw_d    <= 1'b0;
      flt_d    <= 1'b0;
      en_d     <= 1'b0;
    end else begin
      vld_q    <= 1'b1;
      cfg_d    <= {flt_cnt_i, flt_div_i};
      steady_d <= steady;
      raw_d    <= raw_o;
      flt_d    <= flt_o;
      en_d     <= en_i;
    end
  end

  a_r2_outputs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!raw_o && !flt_o && !pin_o));

  a_r3_bypass_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && flt_cnt_i == '0) |-> (flt_o == raw_o));

  a_r4_flip_takes_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady_d && steady && (flt_o != flt_d)) |-> (flt_o == raw_d));

  a_r4_single_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady_d && steady && flt_cnt_i == CNT_W'(1) && flt_div_i == 2'b00) |-> (flt_o == raw_d));

  a_r7_pin_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_o == (out_sel_i ? flt_o : raw_o));

  a_r8_reenable_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !en_d && en_i && flt_cnt_i != '0) |-> !flt_o);
endmodule

bind cmp_glitch_filter cmp_glitch_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .flt_cnt_i (flt_cnt_i),
  .flt_div_i (flt_div_i),
  .out_sel_i (out_sel_i),
  .raw_o     (raw_o),
  .flt_o     (flt_o),
  .pin_o     (pin_o)
);

// File: tb/sim_cmp_glitch_filter.sv
`timescale 1ns/1ps
module sim_cmp_glitch_filter;
  logic       clk = 1'b0;
  logic       rst_ni, en, cmp_raw, inv, out_sel;
  logic [2:0] fcnt;
  logic [1:0] fdiv;
  logic       raw_o, flt_o, pin_o;
  int         checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  cmp_glitch_filter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cmp_raw_i(cmp_raw), .inv_i(inv),
    .flt_cnt_i(fcnt), .flt_div_i(fdiv), .out_sel_i(out_sel),
    .raw_o(raw_o), .flt_o(flt_o), .pin_o(pin_o)
  );

  // {count code, divider code}
  localparam logic [4:0] VEC [8] = '{
    {3'd1, 2'd0}, {3'd2, 2'd0}, {3'd3, 2'd0}, {3'd4, 2'd1},
    {3'd5, 2'd2}, {3'd2, 2'd3}, {3'd7, 2'd1}, {3'd7, 2'd2}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 50000", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // advance k rising edges, end on the following falling edge
  task automatic wait_e(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int div_of(logic [1:0] d);
    return (d == 2'd1) ? 2 : (d == 2'd2) ? 4 : 1;
  endfunction

  initial begin
    rst_ni = 1'b0; en = 1'b0; cmp_raw = 1'b0; inv = 1'b0; out_sel = 1'b0;
    fcnt = 3'd0; fdiv = 2'd0;
    wait_e(3);
    chk("R2 reset raw", raw_o, 1'b0);
    chk("R2 reset flt", flt_o, 1'b0);
    chk("R2 reset pin", pin_o, 1'b0);
    rst_ni = 1'b1;

    // R1/R3/R7/R9: synchronizer latency, bypass, inversion
    en = 1'b1;
    wait_e(4);
    cmp_raw = 1'b1;
    wait_e(1);
    chk("R1 one edge", raw_o, 1'b0);
    wait_e(1);
    chk("R1 two edges", raw_o, 1'b1);
    chk("R3 bypass", flt_o, 1'b1);
    chk("R7 pin raw", pin_o, 1'b1);
    inv = 1'b1; #1;
    chk("R9 invert", raw_o, 1'b0);
    chk("R3 bypass inv", flt_o, 1'b0);
    wait_e(0);
    inv = 1'b0; cmp_raw = 1'b0;
    wait_e(4);

    // vector walk: rising and falling runs per code/divider pair
    for (int i = 0; i < 8; i++) begin
      int n, d, pre;
      string tag;
      fcnt = VEC[i][4:2]; fdiv = VEC[i][1:0];
      n = 1 << (fcnt - 1); d = div_of(fdiv);
      pre = 2 + (n - 1) * d;
      tag = (fcnt == 3'd7 && fdiv != 2'd0) ? "R6" : (fdiv != 2'd0) ? "R5" : "R4";
      cmp_raw = 1'b0;
      wait_e(4);
      chk({tag, " idle"}, flt_o, 1'b0);
      cmp_raw = 1'b1;
      wait_e(pre);
      chk({tag, " rise early"}, flt_o, 1'b0);
      wait_e(d);
      chk({tag, " rise due"}, flt_o, 1'b1);
      cmp_raw = 1'b0;
      wait_e(pre);
      chk({tag, " fall early"}, flt_o, 1'b1);
      wait_e(d);
      chk({tag, " fall due"}, flt_o, 1'b0);
    end

    // R4: interrupted run restarts
    fcnt = 3'd3; fdiv = 2'd0; cmp_raw = 1'b0;
    wait_e(4);
    cmp_raw = 1'b1;
    wait_e(3);
    cmp_raw = 1'b0;
    wait_e(10);
    chk("R4 short run ignored", flt_o, 1'b0);
    cmp_raw = 1'b1;
    wait_e(5);
    chk("R4 count restarted", flt_o, 1'b0);
    wait_e(1);
    chk("R4 full run", flt_o, 1'b1);

    // R8: reconfiguration in the cycle before a due flip
    fcnt = 3'd4; fdiv = 2'd0; cmp_raw = 1'b0;
    wait_e(4);
    cmp_raw = 1'b1;
    wait_e(9);
    chk("R8 before flip", flt_o, 1'b0);
    fdiv = 2'd3;
    wait_e(1);
    chk("R8 clear beats flip", flt_o, 1'b0);
    wait_e(7);
    chk("R8 fresh run early", flt_o, 1'b0);
    wait_e(1);
    chk("R8 fresh run due", flt_o, 1'b1);
    fdiv = 2'd0;
    wait_e(1);
    chk("R8 clears high output", flt_o, 1'b0);
    wait_e(8);
    chk("R8 regained", flt_o, 1'b1);

    // R2: disable forces outputs, re-enable restarts filter
    out_sel = 1'b1; #1;
    chk("R7 pin filtered", pin_o, 1'b1);
    en = 1'b0; #1;
    chk("R2 raw off", raw_o, 1'b0);
    chk("R2 flt off", flt_o, 1'b0);
    chk("R2 pin off", pin_o, 1'b0);
    wait_e(2);
    en = 1'b1; #1;
    chk("R2 re-enable raw", raw_o, 1'b1);
    chk("R2 re-enable flt", flt_o, 1'b0);
    wait_e(7);
    chk("R2 rerun early", flt_o, 1'b0);
    wait_e(1);
    chk("R2 rerun due", flt_o, 1'b1);

    // R7: pin source select while filter lags
    fcnt = 3'd7; fdiv = 2'd0; cmp_raw = 1'b0;
    wait_e(4);
    cmp_raw = 1'b1;
    wait_e(10);
    out_sel = 1'b0; #1;
    chk("R7 sel raw", pin_o, 1'b1);
    out_sel = 1'b1; #1;
    chk("R7 sel filtered", pin_o, 1'b0);
    wait_e(2);

    summary();
  end
endmodule